// File: doc/BRIEF.md
# Power-Fail Qualifier and Host Bus Lockout

This block sits between the host bus pins of a battery-backed timekeeping device and its register file. It samples an active-low power-fail pin through a synchronizer. It then qualifies the pin with a debounce timer driven by a 1 ms tick, in both directions. While a power failure is in force, the block isolates the register file from the host. Chip select, read and write are held inactive, address and write data are forced to zero, and read-data drive is withheld.

An access that is under way when the failure is declared may run to its end. If that access is still held too long after the declaration, isolation is imposed anyway. The block also keeps a power-fail status bit and its masked interrupt. On the rising edge of a standby (battery switchover) flag, it emits one-cycle clear pulses. One pulse clears the time-save enable. The other clears the interrupt enables, and it is sent only when interrupts are not meant to survive on backup power.

Top module: `pfl_top`

## Requirements
- R1: The pin, after a two-stage synchronizer, must be seen low on DEBOUNCE_TICKS consecutive tick pulses before `pf_o` rises. With the defaults (32 ticks of 1 ms), this lands inside a 30 to 63 ms window.
- R2: If the synchronized pin returns to its current qualified state before the count completes, the debounce count restarts from zero.
- R3: After `pf_o` is high, the synchronized pin must be seen high on DEBOUNCE_TICKS consecutive ticks before `pf_o` falls. `locked_o` falls one cycle after `pf_o` falls.
- R4: When `pf_o` is high and no access is active, `locked_o` rises on the next clock. An access is active when `cs_ni` is low and `rd_ni` or `wr_ni` is low.
- R5: When an access is active as `pf_o` rises, `locked_o` stays low while that access continues. It rises on the clock after the access ends.
- R6: If the access stays active, `locked_o` is forced high on the FORCE_TICKS-th tick (default 30) counted after `pf_o` rose.
- R7: While `locked_o` is high, `cs_no`, `rd_no` and `wr_no` are 1, `addr_o` and `wdata_o` are 0, and `rd_drive_o` is 0. While it is low, the strobes, address and data pass through unchanged, and `rd_drive_o` equals (!cs_ni && !rd_ni).
- R8: `pf_status_o` is set one clock after `pf_o` is high while the synchronized pin is low. It clears one clock after the synchronized pin is high, even if `pf_o` is still high. `pf_irq_o` = `pf_status_o` && `pf_ie_i`.
- R9: On a 0-to-1 transition of `standby_i`, `tse_clr_o` pulses high for exactly one cycle, starting one clock after the transition is sampled. `ien_clr_o` pulses in the same cycle only if `irq_on_backup_i` is 0. Neither pulses because of the power-fail pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse every 1 ms |
| pfail_ni | input | 1 | Asynchronous power-fail pin, low means failing |
| standby_i | input | 1 | Battery standby flag |
| irq_on_backup_i | input | 1 | Keep interrupt enables through standby |
| pf_ie_i | input | 1 | Power-fail interrupt enable |
| cs_ni | input | 1 | Host chip select, active low |
| rd_ni | input | 1 | Host read strobe, active low |
| wr_ni | input | 1 | Host write strobe, active low |
| addr_i | input | ADDR_W | Host address |
| wdata_i | input | DATA_W | Host write data |
| cs_no | output | 1 | Gated chip select to register file |
| rd_no | output | 1 | Gated read strobe |
| wr_no | output | 1 | Gated write strobe |
| addr_o | output | ADDR_W | Gated address |
| wdata_o | output | DATA_W | Gated write data |
| rd_drive_o | output | 1 | Permission to drive the read data bus |
| pf_o | output | 1 | Qualified internal power-fail signal |
| locked_o | output | 1 | Host bus isolated |
| pf_status_o | output | 1 | Power-fail status bit |
| pf_irq_o | output | 1 | Masked power-fail interrupt |
| tse_clr_o | output | 1 | Clear pulse for the time-save enable |
| ien_clr_o | output | 1 | Clear pulse for the interrupt enables |

## Verification
Several properties are checked on every cycle. The debounce count stays in range, and `pf_o` only changes on a tick. Isolation only follows a declared failure, an idle bus locks on the next clock, status drops once the pin is high, and the clear pulses last a single cycle. The remaining behaviour is shown only by the bench's scenarios, driven against a behavioural reference: the restart after a glitch, the exact tick counts in both directions, the grace period for an access in progress, the forced lockout after a held strobe, and the choice between one clear pulse and two.

// File: rtl/pfl_pkg.sv
package pfl_pkg;
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/pfl_sync.sv
module pfl_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pfl_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pfl_debounce.sv
module pfl_debounce #(
   parameter int unsigned TICKS = 32,
   parameter int unsigned CNT_W = 6
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic pin_ok_i,
   output logic fail_o
);
   generate
      if (TICKS < 2) begin : g_bad_ticks
         $error("pfl_debounce: TICKS must be at least 2");
      end
      if ((2 ** CNT_W) <= TICKS) begin : g_bad_width
         $error("pfl_debounce: CNT_W too narrow for TICKS");
      end
   endgenerate

   logic             fail_q;
   logic [CNT_W-1:0] cnt_q;
   logic             differs;

   assign differs = (~pin_ok_i) != fail_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         fail_q <= 1'b0;
         cnt_q  <= '0;
      end else if (!differs) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         if (cnt_q == CNT_W'(TICKS - 1)) begin
            fail_q <= ~pin_ok_i;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign fail_o = fail_q;

   // R1 R2 R3: the count never reaches the terminal value
   assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q < CNT_W'(TICKS))
      else $error("debounce count out of range");

   // R1 R3: the qualified state only moves on a tick
   assert_edge_on_tick_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(fail_q) |-> $past(tick_i))
      else $error("qualified state changed without a tick");
endmodule

// File: rtl/pfl_lockout.sv
module pfl_lockout #(
   parameter int unsigned FORCE_TICKS = 30,
   parameter int unsigned FCNT_W      = 5
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic fail_i,
   input  logic access_i,
   output logic locked_o
);
   generate
      if (FORCE_TICKS < 1) begin : g_bad_force
         $error("pfl_lockout: FORCE_TICKS must be at least 1");
      end
      if ((2 ** FCNT_W) <= FORCE_TICKS) begin : g_bad_fwidth
         $error("pfl_lockout: FCNT_W too narrow for FORCE_TICKS");
      end
   endgenerate

   logic              locked_q;
   logic [FCNT_W-1:0] fcnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         locked_q <= 1'b0;
         fcnt_q   <= '0;
      end else if (!fail_i) begin
         locked_q <= 1'b0;
         fcnt_q   <= '0;
      end else if (!locked_q) begin
         if (!access_i) begin
            locked_q <= 1'b1;
         end else if (tick_i) begin
            if (fcnt_q == FCNT_W'(FORCE_TICKS - 1)) locked_q <= 1'b1;
            else                                    fcnt_q   <= fcnt_q + 1'b1;
         end
      end
   end

   assign locked_o = locked_q;

   // R4: isolation follows a declared failure only
   assert_lock_needs_fail_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      locked_q |-> $past(fail_i))
      else $error("locked without a declared failure");

   // R4: an idle bus is locked on the next clock
   assert_idle_locks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fail_i && !locked_q && !access_i) |=> locked_q)
      else $error("idle bus not locked");

   // R6: the force counter stays below its limit
   assert_force_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fcnt_q < FCNT_W'(FORCE_TICKS))
      else $error("force counter out of range");
endmodule

// File: rtl/pfl_standby.sv
module pfl_standby (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic standby_i,
   input  logic irq_on_backup_i,
   output logic tse_clr_o,
   output logic ien_clr_o
);
   logic stby_q;
   logic tse_q;
   logic ien_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stby_q <= 1'b0;
         tse_q  <= 1'b0;
         ien_q  <= 1'b0;
      end else begin
         stby_q <= standby_i;
         tse_q  <= standby_i & ~stby_q;
         ien_q  <= standby_i & ~stby_q & ~irq_on_backup_i;
      end
   end

   assign tse_clr_o = tse_q;
   assign ien_clr_o = ien_q;

   // R9: each clear is a single-cycle pulse
   assert_tse_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tse_q |=> !tse_q)
      else $error("time-save clear longer than one cycle");

   // R9: enable clear never appears alone
   assert_ien_with_tse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ien_q |-> tse_q)
      else $error("enable clear without time-save clear");
endmodule

// File: rtl/pfl_top.sv
module pfl_top #(
   parameter int unsigned ADDR_W         = 5,
   parameter int unsigned DATA_W         = 8,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned DEBOUNCE_TICKS = 32,
   parameter int unsigned FORCE_TICKS    = 30
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              pfail_ni,
   input  logic              standby_i,
   input  logic              irq_on_backup_i,
   input  logic              pf_ie_i,
   input  logic              cs_ni,
   input  logic              rd_ni,
   input  logic              wr_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              cs_no,
   output logic              rd_no,
   output logic              wr_no,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic              rd_drive_o,
   output logic              pf_o,
   output logic              locked_o,
   output logic              pf_status_o,
   output logic              pf_irq_o,
   output logic              tse_clr_o,
   output logic              ien_clr_o
);
   import pfl_pkg::*;

   localparam int unsigned CNT_W  = cnt_width(DEBOUNCE_TICKS);
   localparam int unsigned FCNT_W = cnt_width(FORCE_TICKS);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_bus
         $error("pfl_top: bus widths must be positive");
      end
   endgenerate

   logic pin_sync;
   logic fail;
   logic locked;
   logic access;
   logic status_q;

   pfl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pfail_ni),
      .q_o   (pin_sync)
   );

   pfl_debounce #(.TICKS(DEBOUNCE_TICKS), .CNT_W(CNT_W)) u_deb (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .pin_ok_i(pin_sync),
      .fail_o  (fail)
   );

   assign access = ~cs_ni & (~rd_ni | ~wr_ni);

   pfl_lockout #(.FORCE_TICKS(FORCE_TICKS), .FCNT_W(FCNT_W)) u_lock (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .fail_i  (fail),
      .access_i(access),
      .locked_o(locked)
   );

   pfl_standby u_stby (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .standby_i      (standby_i),
      .irq_on_backup_i(irq_on_backup_i),
      .tse_clr_o      (tse_clr_o),
      .ien_clr_o      (ien_clr_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       status_q <= 1'b0;
      else if (pin_sync) status_q <= 1'b0;
      else if (fail)     status_q <= 1'b1;
   end

   assign cs_no       = cs_ni | locked;
   assign rd_no       = rd_ni | locked;
   assign wr_no       = wr_ni | locked;
   assign addr_o      = locked ? '0 : addr_i;
   assign wdata_o     = locked ? '0 : wdata_i;
   assign rd_drive_o  = ~locked & ~cs_ni & ~rd_ni;
   assign pf_o        = fail;
   assign locked_o    = locked;
   assign pf_status_o = status_q;
   assign pf_irq_o    = status_q & pf_ie_i;

   // R8: status drops once the synchronized pin is high
   assert_status_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pin_sync |=> !status_q)
      else $error("status held with pin high");

   // R8: status is only raised by a declared failure
   assert_status_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status_q) |-> $past(fail))
      else $error("status set without failure");

   // R7: no strobe reaches the register file while isolated
   assert_isolated_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      locked_o |-> (cs_no && !rd_drive_o && addr_o == '0))
      else $error("bus leaked while isolated");
endmodule

// File: tb/pfl_top_bench.sv
module pfl_top_bench;
   localparam int AW = 5;
   localparam int DW = 8;
   localparam int TERM = 32;
   localparam int FORCE = 30;
   localparam int TICK_P = 20;
   localparam int WATCHDOG = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic pin = 1'b1, standby = 1'b0, backup = 1'b0, pf_ie = 1'b1;
   logic cs = 1'b1, rd = 1'b1, wr = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic cs_o, rd_o, wr_o, rd_drive, pf, locked, stat, irq, tse, ien;
   logic [AW-1:0] addr_o;
   logic [DW-1:0] wdata_o;

   always #5 clk = ~clk;

   pfl_top #(.ADDR_W(AW), .DATA_W(DW), .DEBOUNCE_TICKS(TERM), .FORCE_TICKS(FORCE)) u_pfl_top (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .pfail_ni(pin),
      .standby_i(standby), .irq_on_backup_i(backup), .pf_ie_i(pf_ie),
      .cs_ni(cs), .rd_ni(rd), .wr_ni(wr), .addr_i(addr), .wdata_i(wdata),
      .cs_no(cs_o), .rd_no(rd_o), .wr_no(wr_o), .addr_o(addr_o), .wdata_o(wdata_o),
      .rd_drive_o(rd_drive), .pf_o(pf), .locked_o(locked), .pf_status_o(stat),
      .pf_irq_o(irq), .tse_clr_o(tse), .ien_clr_o(ien)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
      end
   endtask

   // tick generator
   int tdiv = 0;
   always @(negedge clk) begin
      #1;
      tdiv = (tdiv == TICK_P - 1) ? 0 : tdiv + 1;
      tick = (tdiv == 0);
   end

   // behavioural reference
   bit m_s1 = 1, m_s2 = 1, m_pf = 0, m_lock = 0, m_stat = 0, m_sq = 0, m_tse = 0, m_ien = 0;
   int m_cnt = 0, m_fc = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 = 1; m_s2 = 1; m_pf = 0; m_lock = 0; m_stat = 0;
         m_sq = 0; m_tse = 0; m_ien = 0; m_cnt = 0; m_fc = 0;
      end else begin
         bit busy;
         bit want_fail;
         busy = !cs && (!rd || !wr);
         if (!m_pf) begin
            m_lock = 0; m_fc = 0;
         end else if (!m_lock) begin
            if (!busy) m_lock = 1;
            else if (tick) begin
               if (m_fc + 1 >= FORCE) m_lock = 1;
               else m_fc++;
            end
         end
         if (m_s2) m_stat = 0;
         else if (m_pf) m_stat = 1;
         want_fail = !m_s2;
         if (want_fail == m_pf) m_cnt = 0;
         else if (tick) begin
            m_cnt++;
            if (m_cnt == TERM) begin m_pf = want_fail; m_cnt = 0; end
         end
         m_s2 = m_s1; m_s1 = pin;
         m_tse = standby && !m_sq;
         m_ien = m_tse && !backup;
         m_sq = standby;
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         cmp("R1/R3 pf_o", pf, m_pf);
         cmp("R4/R5/R6 locked_o", locked, m_lock);
         cmp("R7 cs_no", cs_o, cs | m_lock);
         cmp("R7 rd_no", rd_o, rd | m_lock);
         cmp("R7 wr_no", wr_o, wr | m_lock);
         cmp("R7 addr_o", addr_o, m_lock ? 0 : addr);
         cmp("R7 wdata_o", wdata_o, m_lock ? 0 : wdata);
         cmp("R7 rd_drive_o", rd_drive, !m_lock && !cs && !rd);
         cmp("R8 pf_status_o", stat, m_stat);
         cmp("R8 pf_irq_o", irq, m_stat && pf_ie);
         cmp("R9 tse_clr_o", tse, m_tse);
         cmp("R9 ien_clr_o", ien, m_ien);
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
      #2;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired: actual running expected finished");
      finish_run();
   end

   initial begin
      step(3);
      cmp("R1 reset pf_o", pf, 0);
      cmp("R4 reset locked_o", locked, 0);
      rst_n = 1'b1;
      step(5);
      // normal read passes through
      cs = 0; rd = 0; addr = 5'h0B; step(2);
      cmp("R7 passthrough drive", rd_drive, 1);
      cmp("R7 passthrough addr", addr_o, 5'h0B);
      cs = 1; rd = 1; step(2);
      // glitch during debounce
      pin = 0; step(400);
      pin = 1; step(10);
      pin = 0; step(400);
      cmp("R2 restart after glitch", pf, 0);
      step(300);
      cmp("R1 declared", pf, 1);
      cmp("R9 no clear from pin", tse, 0);
      cmp("R4 idle lock", locked, 1);
      cs = 0; rd = 0; addr = 5'h07; wdata = 8'hA5; step(1);
      cmp("R7 cs blocked", cs_o, 1);
      cmp("R7 addr blocked", addr_o, 0);
      cmp("R7 no drive", rd_drive, 0);
      cs = 1; rd = 1; step(1);
      cmp("R8 status set", stat, 1);
      cmp("R8 irq", irq, 1);
      pf_ie = 0; step(1);
      cmp("R8 irq masked", irq, 0);
      pf_ie = 1;
      // release
      pin = 1; step(4);
      cmp("R8 status cleared", stat, 0);
      cmp("R3 still declared", pf, 1);
      cmp("R3 still locked", locked, 1);
      step(700);
      cmp("R3 released", pf, 0);
      cmp("R3 unlocked", locked, 0);
      // access in progress finishes
      cs = 0; wr = 0; wdata = 8'h3C; step(2);
      pin = 0; step(700);
      cmp("R5 declared", pf, 1);
      cmp("R5 access allowed", locked, 0);
      cmp("R5 write passes", wr_o, 0);
      cs = 1; wr = 1; step(2);
      cmp("R5 lock after access", locked, 1);
      pin = 1; step(720);
      cmp("R3 unlock again", locked, 0);
      // held strobe forces lockout
      cs = 0; rd = 0; step(2);
      pin = 0; step(700);
      cmp("R6 not yet forced", locked, 0);
      step(FORCE * TICK_P + 40);
      cmp("R6 forced", locked, 1);
      cmp("R7 held cs blocked", cs_o, 1);
      cs = 1; rd = 1;
      pin = 1; step(720);
      // standby clears
      backup = 0; standby = 1; step(1);
      cmp("R9 tse pulse", tse, 1);
      cmp("R9 ien pulse", ien, 1);
      step(1);
      cmp("R9 tse single", tse, 0);
      standby = 0; step(3);
      backup = 1; standby = 1; step(1);
      cmp("R9 tse pulse kept", tse, 1);
      cmp("R9 ien held off", ien, 0);
      step(5);
      finish_run();
   end
endmodule